// File: doc/BRIEF.md
# Address Bus Parity Generator and Snoop Checker

This block protects a 32-bit address bus with one odd parity bit per address byte. While the local agent owns the address bus and presents a valid address, the block computes the four parity bits from the outgoing address and drives them beside it. When the agent is not the owner, the block watches the incoming bus. A snoopable memory cycle is qualified when the incoming start strobe and the global attribute are asserted in the same cycle. In such a cycle the block recomputes parity on the incoming address and compares it with the incoming parity bits.

A mismatch raises a one-clock error pulse, but only while address parity checking is enabled. If the machine-check enable is clear in the cycle of that error, the error also sets a checkstop request. The request stays set until reset. Handling of the checkstop is left to the logic around this block.

The bus is not buffered and has no back-pressure: there is no valid/ready handshake. Parity is produced in the same cycle as the address. Each qualified snoop cycle is judged exactly once, and nothing is held back.

Top module: `addr_parity_unit`

## Requirements
- R1: While driving, `par_out[k]` is the odd parity of `addr_out[31-8k:24-8k]`, so that byte plus its bit holds an odd count of ones. `par_out[0]` covers the most significant byte.
- R2: `par_out` is all zeros whenever `is_master` and `addr_valid` are not both high.
- R3: A comparison happens only in a cycle with `is_master` low and `start_in` and `global_in` both high. In any other cycle, `par_err` stays low in the following clock.
- R4: A qualified cycle whose recomputed parity differs from `par_in`, with `chk_en` high, makes `par_err` high for exactly the next clock.
- R5: With `chk_en` low, a mismatching qualified cycle raises neither `par_err` nor `stop_req`.
- R6: `stop_req` becomes high on the same edge as a `par_err` pulse whose cycle had `mchk_en` low. A pulse whose cycle had `mchk_en` high leaves `stop_req` unchanged.
- R7: Once high, `stop_req` stays high until `rst_n` is asserted.
- R8: While `rst_n` is low, and right after it, `par_err` and `stop_req` are low.
- R9: A single flipped bit in any one of the four incoming bytes, or in any one parity bit, is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Local agent owns the address bus |
| addr_valid | input | 1 | Outgoing address is valid |
| addr_out | input | 32 | Outgoing address |
| par_out | output | 4 | Generated parity; bit 0 covers byte 31:24 |
| addr_in | input | 32 | Incoming address seen on the bus |
| par_in | input | 4 | Incoming parity; bit 0 covers byte 31:24 |
| start_in | input | 1 | Incoming transfer start strobe |
| global_in | input | 1 | Incoming global (snoopable) attribute |
| chk_en | input | 1 | Address parity checking enable |
| mchk_en | input | 1 | Machine-check enable |
| par_err | output | 1 | One-clock parity error pulse |
| stop_req | output | 1 | Sticky checkstop request |

## Verification
An error pulse and the first rise of the checkstop request can land on the same edge. The bench provokes this with a corrupted qualified cycle while `mchk_en` is low. It then samples both outputs after that edge and expects both high together. It also corrupts further qualified cycles while the request is already set, and expects a fresh one-clock pulse each time with the request still held. Random vectors mix master cycles, cycles missing the global attribute, and single-bit corruptions in every byte. Each cycle is judged against a bench model of odd parity and qualification.

// File: rtl/apar_pkg.sv
package apar_pkg;
  localparam int LANE_W = 8;

  // odd parity: bit that makes (byte, bit) hold an odd number of ones
  function automatic logic odd_bit(input logic [LANE_W-1:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/apar_lane_gen.sv
module apar_lane_gen
  import apar_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int NL = ADDR_W / LANE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NL-1:0]     par
);
  // lane 0 is the most significant byte
  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign par[k] = odd_bit(addr[ADDR_W-1-k*LANE_W -: LANE_W]);
  end
endmodule

// File: rtl/apar_snoop_chk.sv
module apar_snoop_chk #(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          start_in,
  input  logic          global_in,
  input  logic          chk_en,
  input  logic [NL-1:0] calc,
  input  logic [NL-1:0] par_in,
  output logic          err_evt,
  output logic          par_err
);
  logic qual;
  logic mism;

  assign qual    = !is_master && start_in && global_in;
  assign mism    = |(calc ^ par_in);
  assign err_evt = qual && mism && chk_en;

  always_ff @(posedge clk) begin
    if (!rst_n) par_err <= 1'b0;
    else        par_err <= err_evt;
  end

  // R3
  qual_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(!is_master && start_in && global_in));

  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(chk_en));

  // R4
  mism_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(calc != par_in));
endmodule

// File: rtl/apar_stop_latch.sv
module apar_stop_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic mchk_en,
  output logic stop_req
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    stop_req <= 1'b0;
    else if (err_evt && !mchk_en)  stop_req <= 1'b1;
  end

  // R7
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> stop_req);

  // R6
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(err_evt && !mchk_en));
endmodule

// File: rtl/addr_parity_unit.sv
module addr_parity_unit
  import apar_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int NL = ADDR_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_out,
  output logic [NL-1:0]     par_out,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [NL-1:0]     par_in,
  input  logic              start_in,
  input  logic              global_in,
  input  logic              chk_en,
  input  logic              mchk_en,
  output logic              par_err,
  output logic              stop_req
);
  logic [NL-1:0] gen_par;
  logic [NL-1:0] chk_par;
  logic          drive;
  logic          err_evt;

  apar_lane_gen #(.ADDR_W(ADDR_W)) u_gen_out (
    .addr (addr_out),
    .par  (gen_par)
  );

  apar_lane_gen #(.ADDR_W(ADDR_W)) u_gen_in (
    .addr (addr_in),
    .par  (chk_par)
  );

  assign drive   = is_master && addr_valid;
  assign par_out = drive ? gen_par : '0;

  apar_snoop_chk #(.NL(NL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .start_in  (start_in),
    .global_in (global_in),
    .chk_en    (chk_en),
    .calc      (chk_par),
    .par_in    (par_in),
    .err_evt   (err_evt),
    .par_err   (par_err)
  );

  apar_stop_latch u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .mchk_en  (mchk_en),
    .stop_req (stop_req)
  );

  for (genvar k = 0; k < NL; k++) begin : g_odd
    // R1
    odd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (^{addr_out[ADDR_W-1-k*LANE_W -: LANE_W], par_out[k]}) == 1'b1);
  end

  // R2
  par_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_master && addr_valid) |-> par_out == '0);

  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(err_evt));
endmodule

// File: tb/test_addr_parity_unit.sv
module test_addr_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_master = 1'b0, addr_valid = 1'b0;
  logic [31:0] addr_out = '0, addr_in = '0;
  logic [3:0]  par_in = '0;
  logic        start_in = 1'b0, global_in = 1'b0, chk_en = 1'b1, mchk_en = 1'b1;
  logic [3:0]  par_out;
  logic        par_err, stop_req;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_stop = 1'b0;

  always #4 clk = ~clk;

  addr_parity_unit i_addr_parity_unit (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .addr_valid(addr_valid),
    .addr_out(addr_out), .par_out(par_out), .addr_in(addr_in), .par_in(par_in),
    .start_in(start_in), .global_in(global_in), .chk_en(chk_en), .mchk_en(mchk_en),
    .par_err(par_err), .stop_req(stop_req)
  );

  function automatic logic [3:0] ref_par(input logic [31:0] a);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ~(^a[31-8*k -: 8]);
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, judge comb parity, then registered outputs
  task automatic cyc(input logic m, input logic v, input logic [31:0] ao,
                     input logic [31:0] ai, input logic [3:0] pi,
                     input logic st, input logic gl, input logic ce, input logic mce,
                     input string req);
    logic e;
    @(negedge clk);
    is_master = m; addr_valid = v; addr_out = ao; addr_in = ai; par_in = pi;
    start_in = st; global_in = gl; chk_en = ce; mchk_en = mce;
    #1;
    check({req, "/R1R2 par_out"}, {28'd0, par_out}, {28'd0, (m && v) ? ref_par(ao) : 4'd0});
    e = !m && st && gl && ce && (ref_par(ai) != pi);
    if (e && !mce) exp_stop = 1'b1;
    @(posedge clk); #1;
    check({req, " par_err"}, {31'd0, par_err}, {31'd0, e});
    check({req, " stop_req"}, {31'd0, stop_req}, {31'd0, exp_stop});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start_in = 0; global_in = 0;
    @(posedge clk); #1;
    exp_stop = 1'b0;
    check("R8 par_err", {31'd0, par_err}, 32'd0);
    check("R8 stop_req", {31'd0, stop_req}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 directed values
    cyc(1, 1, 32'h0000_0000, 0, 0, 0, 0, 1, 1, "R1 zero");
    cyc(1, 1, 32'h0100_0000, 0, 0, 0, 0, 1, 1, "R1 msb lane");
    check("R1 lane order", {28'd0, par_out}, 32'he);
    cyc(1, 1, 32'h0000_0007, 0, 0, 0, 0, 1, 1, "R1 lsb lane");
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1, "R2 not valid");
    cyc(0, 1, 32'h1234_5678, 0, 0, 0, 0, 1, 1, "R2 not master");
    // R9 single bit flip in each byte, and in each parity bit
    for (int k = 0; k < 4; k++) begin
      a = 32'hA5C3_0F96;
      cyc(0, 0, 0, a ^ (32'h1 << (8*k + k)), ref_par(a), 1, 1, 1, 1, "R9 R4 byte flip");
      cyc(0, 0, 0, a, ref_par(a) ^ (4'h1 << k), 1, 1, 1, 1, "R9 parity flip");
    end
    cyc(0, 0, 0, 32'h1111_1111, ref_par(32'h1111_1111), 1, 1, 1, 1, "R4 clean");
    // R3 unqualified cycles with bad parity
    cyc(0, 0, 0, 32'h1, 4'h0, 1, 0, 1, 0, "R3 no global");
    cyc(0, 0, 0, 32'h1, 4'h0, 0, 1, 1, 0, "R3 no start");
    cyc(1, 1, 32'h2, 32'h1, 4'h0, 1, 1, 1, 0, "R3 master");
    // R5 checking disabled
    cyc(0, 0, 0, 32'h1, 4'h0, 1, 1, 0, 0, "R5 disabled");
    // R6 error with machine check set leaves stop low, then clear sets it
    cyc(0, 0, 0, 32'h1, 4'h0, 1, 1, 1, 1, "R6 mce set");
    cyc(0, 0, 0, 32'h1, 4'h0, 1, 1, 1, 0, "R6 mce clear");
    // R7 stays set, new pulses still come
    cyc(0, 0, 0, 32'h3, 4'h0, 1, 1, 1, 1, "R7 err while stop");
    cyc(0, 0, 0, 0, 4'hF, 1, 1, 1, 1, "R7 clean while stop");
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ai;
      logic [3:0]  pi;
      ai = $urandom;
      pi = ref_par(ai);
      if ($urandom_range(0, 1) == 1) begin
        if ($urandom_range(0, 1) == 1) ai = ai ^ (32'h1 << $urandom_range(0, 31));
        else pi = pi ^ (4'h1 << $urandom_range(0, 3));
      end
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, $urandom, ai, pi,
          $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
          $urandom_range(0, 4) != 0, $urandom_range(0, 30) != 0, "R3R4R6 random");
      if (i == 300) do_reset();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule